// File: doc/BRIEF.md
# JTAG Debug Data-In Mailbox

This block extends a test access port so that an external host can pass 32-bit words into a processor. The host drives the four TAP pins. It loads an instruction that selects a 33-bit input register and scans in a payload word together with a full flag. When the flag arrives set and the mailbox is empty, the word is held and a full flag is raised. On the processor side, that flag shows up as an interrupt. The processor reads the held word from a parallel port and empties the mailbox with a one-cycle clear strobe.

The host never needs a separate status read. Every instruction scan returns three status bits on TDO while the new opcode shifts in, and bit 0 of those is the full flag. The host polls by repeating the input-select instruction scan until it sees the flag low, then scans the next word in. The full flag crosses between the TCK and system clock domains as a pair of toggles, each passing through a two-flop synchroniser. The held word stays stable for the whole time the flag is set. Both resets are expected to be asserted together.

Top module: `jtag_mbx_in`

## Requirements
- R1: The TAP follows the standard 16-state controller. Either five TCK rising edges with TMS high, or trst_n low, reach Test-Logic-Reset, which loads opcode 5'h01 (IDCODE). The IDCODE data register is 32 bits and returns parameter IDCODE, LSB first.
- R2: The instruction register is 5 bits wide. 5'h02 selects the 33-bit input register and 5'h03 selects the 3-bit status register. Every other opcode except 5'h01 selects a 1-bit bypass register that captures 0.
- R3: Capture-IR loads {2'b00, 1'b1, 1'b0, full} into the IR shifter, so bit 0 is the full flag and bit 2 is always 1. These bits leave on TDO LSB first during Shift-IR.
- R4: The input register shifts LSB first. Bits [31:0] are the payload and bit 32 is the full flag. Capture-DR loads {full, held word}.
- R5: At Update-DR, if bit 32 is 1 and the mailbox is empty, the payload is stored and the full flag is set.
- R6: At Update-DR, if bit 32 is 0 or the mailbox is already full, the held word and the flag are left unchanged.
- R7: mbx_irq rises within three clk rising edges after the accepting Update-DR edge. While mbx_irq is high, mbx_data shows the held word and stays stable.
- R8: A mbx_clr pulse while mbx_irq is high drops mbx_irq at that clk edge. Within two TCK edges the TAP then sees the mailbox as empty and accepts a new word.
- R9: The status data register captures the same three status bits {1, 0, full} and discards what is shifted in.
- R10: TDO changes on falling TCK edges. It carries bit 0 of the active shifter in Shift-IR and Shift-DR, and 0 in all other states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| trst_n | input | 1 | Asynchronous TAP reset, active low |
| tdo | output | 1 | Test data out, updated on falling TCK |
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Processor-side asynchronous reset, active low |
| mbx_clr | input | 1 | One-cycle strobe that empties the mailbox |
| mbx_data | output | 32 | Held mailbox word |
| mbx_irq | output | 1 | Interrupt, high while the mailbox is full |

## Verification
A lost or doubled handshake toggle leaves mbx_irq at the wrong level. It also flips bit 0 of the very next instruction-scan capture, so the fault shows within one IR scan, about a dozen TCK cycles. A write that wrongly overwrites a full mailbox changes mbx_data at once, and the input register returns the new word on its next capture. A TAP state error shifts the returned status or IDCODE bits by one position, which the bench compares bit for bit.

// File: rtl/jtag_mbx_in.sv
module jtag_mbx_in #(
  parameter logic [31:0] IDCODE = 32'h1A5C_E01F
) (
  input  logic        tck,
  input  logic        tms,
  input  logic        tdi,
  input  logic        trst_n,
  output logic        tdo,
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mbx_clr,
  output logic [31:0] mbx_data,
  output logic        mbx_irq
);
  localparam logic [4:0] OP_ID   = 5'h01;
  localparam logic [4:0] OP_IN   = 5'h02;
  localparam logic [4:0] OP_STAT = 5'h03;

  typedef enum logic [3:0] {
    TLR, IDLE, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
  } tap_t;

  tap_t        state, nxt;
  logic [4:0]  ir, ir_sr;
  logic [32:0] dr_sr;
  logic [31:0] mbx_q;
  logic        wr_tog, ack_tog;
  logic [1:0]  ack_sync, wr_sync;
  logic        ifull_tck;
  logic [2:0]  status;

  assign ifull_tck = wr_tog ^ ack_sync[1];
  assign status    = {1'b1, 1'b0, ifull_tck};
  assign mbx_data  = mbx_q;
  assign mbx_irq   = wr_sync[1] ^ ack_tog;

  always_comb begin
    case (state)
      TLR:     nxt = tms ? TLR    : IDLE;
      IDLE:    nxt = tms ? SEL_DR : IDLE;
      SEL_DR:  nxt = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nxt = tms ? EX1_DR : SH_DR;
      SH_DR:   nxt = tms ? EX1_DR : SH_DR;
      EX1_DR:  nxt = tms ? UPD_DR : PA_DR;
      PA_DR:   nxt = tms ? EX2_DR : PA_DR;
      EX2_DR:  nxt = tms ? UPD_DR : SH_DR;
      UPD_DR:  nxt = tms ? SEL_DR : IDLE;
      SEL_IR:  nxt = tms ? TLR    : CAP_IR;
      CAP_IR:  nxt = tms ? EX1_IR : SH_IR;
      SH_IR:   nxt = tms ? EX1_IR : SH_IR;
      EX1_IR:  nxt = tms ? UPD_IR : PA_IR;
      PA_IR:   nxt = tms ? EX2_IR : PA_IR;
      EX2_IR:  nxt = tms ? UPD_IR : SH_IR;
      default: nxt = tms ? SEL_DR : IDLE;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state    <= TLR;
      ir       <= OP_ID;
      ir_sr    <= '0;
      dr_sr    <= '0;
      mbx_q    <= '0;
      wr_tog   <= 1'b0;
      ack_sync <= '0;
    end else begin
      state    <= nxt;
      ack_sync <= {ack_sync[0], ack_tog};
      case (state)
        TLR:    ir <= OP_ID;
        CAP_IR: ir_sr <= {2'b00, status};
        SH_IR:  ir_sr <= {tdi, ir_sr[4:1]};
        UPD_IR: ir <= ir_sr;
        CAP_DR:
          case (ir)
            OP_IN:   dr_sr <= {ifull_tck, mbx_q};
            OP_ID:   dr_sr <= {1'b0, IDCODE};
            OP_STAT: dr_sr <= {30'b0, status};
            default: dr_sr <= '0;
          endcase
        SH_DR:
          case (ir)
            OP_IN:   dr_sr       <= {tdi, dr_sr[32:1]};
            OP_ID:   dr_sr[31:0] <= {tdi, dr_sr[31:1]};
            OP_STAT: dr_sr[2:0]  <= {tdi, dr_sr[2:1]};
            default: dr_sr[0]    <= tdi;
          endcase
        UPD_DR:
          if (ir == OP_IN && dr_sr[32] && !ifull_tck) begin
            mbx_q  <= dr_sr[31:0];
            wr_tog <= ~wr_tog;
          end
        default: ;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)              tdo <= 1'b0;
    else if (state == SH_IR)  tdo <= ir_sr[0];
    else if (state == SH_DR)  tdo <= dr_sr[0];
    else                      tdo <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sync <= '0;
      ack_tog <= 1'b0;
    end else begin
      wr_sync <= {wr_sync[0], wr_tog};
      if (mbx_clr && mbx_irq) ack_tog <= ~ack_tog;
    end
  end

  AST_CLR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mbx_clr && mbx_irq) |=> !mbx_irq); // R8
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mbx_irq && $past(mbx_irq)) |-> $stable(mbx_data)); // R7
  AST_BLOCKED_WRITE: assert property (@(posedge tck) disable iff (!trst_n)
    (state == UPD_DR && ir == OP_IN && (ifull_tck || !dr_sr[32])) |=> $stable(mbx_q)); // R6
  AST_WRITE_SETS_FULL: assert property (@(posedge tck) disable iff (!trst_n)
    (state == UPD_DR && ir == OP_IN && dr_sr[32] && !ifull_tck) |=> ifull_tck); // R5
  AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
    (state == CAP_IR) |=> (ir_sr == {4'b0010, $past(ifull_tck)})); // R3
endmodule

// File: tb/test_jtag_mbx_in.sv
module test_jtag_mbx_in;
  localparam int CLK_PERIOD = 10;
  localparam int TCK_HALF   = 20;
  localparam logic [31:0] ID = 32'h1A5C_E01F;
  localparam logic [31:0] VEC [4] = '{32'hA5A5_0001, 32'h0000_0000,
                                      32'hFFFF_FFFF, 32'h1234_5678};

  logic tck = 0, tms = 1, tdi = 0, trst_n = 0, clk = 0, rst_n = 0, mbx_clr = 0;
  logic tdo, mbx_irq;
  logic [31:0] mbx_data;
  int nchk = 0, nfail = 0;
  logic [4:0]  cap;
  logic [32:0] dout;

  jtag_mbx_in #(.IDCODE(ID)) i_jtag_mbx_in (
    .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .tdo(tdo),
    .clk(clk), .rst_n(rst_n), .mbx_clr(mbx_clr),
    .mbx_data(mbx_data), .mbx_irq(mbx_irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    tms = m; tdi = d;
    #(TCK_HALF);
    o = tdo;
    tck = 1;
    #(TCK_HALF);
    tck = 0;
  endtask

  task automatic ir_scan(input logic [4:0] op, output logic [4:0] c);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 5; i++) begin
      step(i == 4, op[i], o);
      c[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic dr_scan(input logic [32:0] din, input int len, output logic [32:0] q);
    logic o;
    q = '0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < len; i++) begin
      step(i == len - 1, din[i], o);
      q[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic clear_mbx();
    @(negedge clk); mbx_clr = 1;
    @(negedge clk); mbx_clr = 0;
    #1;
  endtask

  initial begin
    #(4000000);
    nfail++;
    $display("FAIL R1 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic o;
    #50; trst_n = 1; rst_n = 1;
    step(0, 0, o);
    chk("R7 irq low after reset", {32'b0, mbx_irq}, 33'd0);
    dr_scan(33'd0, 32, dout);
    chk("R1 IDCODE after reset", dout, {1'b0, ID});
    ir_scan(5'h02, cap);
    chk("R3 IR capture empty", {28'b0, cap}, 33'd4);

    foreach (VEC[k]) begin
      ir_scan(5'h02, cap);
      chk("R3 poll shows empty", {28'b0, cap}, 33'd4);
      dr_scan({1'b1, VEC[k]}, 33, dout);
      chk("R7 irq after write", {32'b0, mbx_irq}, 33'd1);
      chk("R5 word held", {1'b0, mbx_data}, {1'b0, VEC[k]});
      ir_scan(5'h02, cap);
      chk("R3 poll shows full", {28'b0, cap}, 33'd5);
      clear_mbx();
      chk("R8 irq dropped by clear", {32'b0, mbx_irq}, 33'd0);
    end

    dr_scan({1'b1, 32'hCAFE_0001}, 33, dout);
    dr_scan({1'b1, 32'hDEAD_0002}, 33, dout);
    chk("R6 write while full ignored", {1'b0, mbx_data}, {1'b0, 32'hCAFE_0001});
    dr_scan(33'd0, 33, dout);
    chk("R4 capture full and word", dout, {1'b1, 32'hCAFE_0001});
    ir_scan(5'h03, cap);
    dr_scan(33'd0, 3, dout);
    chk("R9 status register full", dout, 33'd5);
    ir_scan(5'h02, cap);
    clear_mbx();
    step(0, 0, o); step(0, 0, o);
    dr_scan({1'b1, 32'hDEAD_0002}, 33, dout);
    chk("R8 write accepted after clear", {1'b0, mbx_data}, {1'b0, 32'hDEAD_0002});
    chk("R7 irq after re-enabled write", {32'b0, mbx_irq}, 33'd1);
    clear_mbx();
    step(0, 0, o); step(0, 0, o);

    dr_scan({1'b0, 32'h5555_AAAA}, 33, dout);
    chk("R6 flag clear write ignored", {1'b0, mbx_data}, {1'b0, 32'hDEAD_0002});
    chk("R6 flag clear no irq", {32'b0, mbx_irq}, 33'd0);

    ir_scan(5'h0A, cap);
    dr_scan(33'h0B5, 8, dout);
    chk("R2 bypass one-bit delay", dout, {25'b0, 8'h6A});

    ir_scan(5'h03, cap);
    dr_scan(33'd7, 3, dout);
    chk("R9 status register empty", dout, 33'd4);

    ir_scan(5'h0A, cap);
    for (int i = 0; i < 5; i++) step(1, 0, o);
    step(0, 0, o);
    dr_scan(33'd0, 32, dout);
    chk("R1 TMS reset selects IDCODE", dout, {1'b0, ID});
    #(TCK_HALF);
    chk("R10 tdo low outside shift", {32'b0, tdo}, 33'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule